// File: doc/BRIEF.md
# Four-Phase Handshake Compliance Monitor

This block is a passive observer placed on a single initiator/target link that carries a request/response handshake. Each cycle it may see one phase event. The event carries a phase code, a transaction tag, an address, a direct-memory-access permission flag and a completion indication. The monitor follows each transaction in a small table keyed by tag. It raises sticky error flags when the link breaks the ordering rules, carries more than one request phase at a time, or lets a payload field change on a side that does not own it. It also counts each kind of violation.

A mode input selects full four-phase checking or a reduced two-phase mode, in which a call is answered by a single return. A programmable limit bounds how long the target may leave a request phase open. One instance covers one link, and a system with many links places one monitor on each. A synchronous clear pulse wipes the flags and the counters. It leaves the transaction table alone.

Top module: `cmon_link_checker`

## Requirements
- R1: Phase codes are 0 begin-request, 1 end-request, 2 begin-response, 3 end-response. In four-phase mode a tracked transaction must follow 0,1,2,3. A phase that is neither the expected next one nor a repeat of the last one sets flag bit 0 (order) and leaves the transaction state unchanged.
- R2: A repeat of the phase that last advanced a tracked transaction sets flag bit 1 (duplicate). A begin-request whose tag is still awaiting end-request also sets bit 1.
- R3: A begin-request while any transaction still awaits its end-request (or, in two-phase mode, its return) sets flag bit 2. The new request is not tracked.
- R4: An end-request or begin-response with the completion input high ends the transaction early. Any later phase with that tag, other than a new begin-request, sets flag bit 3. A new begin-request with that tag starts a fresh transaction without error.
- R5: A begin-request with the permission flag high sets flag bit 4.
- R6: The target phases (1, 2) may change the permission flag freely. An end-response that presents a permission value different from the one last recorded sets flag bit 5.
- R7: A target phase (1, 2) whose address differs from the address captured at begin-request sets flag bit 6. The phase still advances the transaction if its order is legal.
- R8: Any phase other than begin-request whose tag matches no tracked transaction sets flag bit 7. A transaction is released after its final phase, so a later phase with that tag sets bit 7.
- R9: When the timeout limit is nonzero and end-request has not come within that many cycles of begin-request, flag bit 8 is set. A limit of zero disables the check.
- R10: A begin-request that finds every one of the SLOTS table entries holding a live transaction sets flag bit 9. Once entries are released, new requests are accepted again.
- R11: In two-phase mode (mode input high), begin-request is the call and begin-response is the return, which releases the transaction. End-request and end-response are order violations (bit 0).
- R12: Flags stay set until a clear pulse. A clear in the same cycle as a violation wins, so the flags read zero afterwards.
- R13: Each flag has an 8-bit saturating counter of its occurrences. Counter k sits at err_cnt_o bits [8k+7:8k], stops at 255 and is zeroed by clear.
- R14: After reset all flags and counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Clear pulse for flags and counters |
| two_phase_i | input | 1 | 1 selects two-phase checking |
| tmo_lim_i | input | TMR_W | End-request timeout in cycles, 0 disables |
| ev_valid_i | input | 1 | A phase event is present this cycle |
| ev_phase_i | input | 2 | Phase code (0..3) |
| ev_id_i | input | ID_W | Transaction tag |
| ev_addr_i | input | ADDR_W | Address carried by the event |
| ev_dmi_i | input | 1 | Direct-memory-access permission flag |
| ev_done_i | input | 1 | Completion indication for early end |
| err_o | output | 10 | Sticky violation flags, bit per code |
| err_cnt_o | output | 10*CNT_W | Saturating per-code occurrence counters |

## Verification
A table entry left in the wrong state shows up at the next event carrying that tag. One cycle after the event, a spurious or missing order, duplicate, orphan or late flag appears. A request-busy indication that is stuck high shows one cycle after the next begin-request as a multiple-request flag. If the limit is nonzero it also shows as a timeout flag a fixed number of cycles later. A stuck-low indication lets a second request through silently, so the stimulus places back-to-back begin-requests in both modes and reads the flags right after the second one.

// File: rtl/cmon_pkg.sv
package cmon_pkg;

   typedef enum logic [1:0] {
      PH_BREQ = 2'd0,
      PH_EREQ = 2'd1,
      PH_BRSP = 2'd2,
      PH_ERSP = 2'd3
   } phase_e;

   typedef enum logic [2:0] {
      ST_FREE    = 3'd0,
      ST_REQ     = 3'd1,
      ST_REQ_END = 3'd2,
      ST_RESP    = 3'd3,
      ST_DONE    = 3'd4
   } slot_st_e;

   localparam int NERR       = 10;
   localparam int E_ORDER    = 0;
   localparam int E_DUP      = 1;
   localparam int E_MULTI    = 2;
   localparam int E_LATE     = 3;
   localparam int E_DMI_INIT = 4;
   localparam int E_DMI_OWN  = 5;
   localparam int E_ADDR     = 6;
   localparam int E_ORPHAN   = 7;
   localparam int E_TIMEOUT  = 8;
   localparam int E_OVERFLOW = 9;

endpackage

// File: rtl/cmon_slot_table.sv
module cmon_slot_table
   import cmon_pkg::*;
#(
   parameter int ID_W   = 4,
   parameter int ADDR_W = 32,
   parameter int SLOTS  = 4,
   parameter int IDX_W  = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ID_W-1:0]   lk_id_i,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic              wr_load_i,
   input  slot_st_e          wr_st_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic              wr_dmi_i,
   output logic              hit_o,
   output logic [IDX_W-1:0]  hit_idx_o,
   output slot_st_e          hit_st_o,
   output logic [ADDR_W-1:0] hit_addr_o,
   output logic              hit_dmi_o,
   output logic              free_ok_o,
   output logic [IDX_W-1:0]  free_idx_o,
   output logic              req_busy_o
);

   slot_st_e          st_q   [SLOTS];
   logic [ID_W-1:0]   id_q   [SLOTS];
   logic [ADDR_W-1:0] addr_q [SLOTS];
   logic              dmi_q  [SLOTS];

   logic [SLOTS-1:0]  match;
   logic [SLOTS-1:0]  avail;
   logic [SLOTS-1:0]  in_req;

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign match[s]  = (st_q[s] != ST_FREE) && (id_q[s] == lk_id_i);
      assign avail[s]  = (st_q[s] == ST_FREE) || (st_q[s] == ST_DONE);
      assign in_req[s] = (st_q[s] == ST_REQ);
   end

   assign req_busy_o = |in_req;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         for (int s = 0; s < SLOTS; s++) begin
            st_q[s]   <= ST_FREE;
            id_q[s]   <= '0;
            addr_q[s] <= '0;
            dmi_q[s]  <= 1'b0;
         end
      end else if (wr_en_i) begin
         for (int s = 0; s < SLOTS; s++) begin
            if (wr_idx_i == IDX_W'(s)) begin
               st_q[s]  <= wr_st_i;
               dmi_q[s] <= wr_dmi_i;
               if (wr_load_i) begin
                  id_q[s]   <= lk_id_i;
                  addr_q[s] <= wr_addr_i;
               end
            end
         end
      end
   end

   always_comb begin
      hit_o      = 1'b0;
      hit_idx_o  = '0;
      hit_st_o   = ST_FREE;
      hit_addr_o = '0;
      hit_dmi_o  = 1'b0;
      for (int s = 0; s < SLOTS; s++) begin
         if (!hit_o && match[s]) begin
            hit_o      = 1'b1;
            hit_idx_o  = IDX_W'(s);
            hit_st_o   = st_q[s];
            hit_addr_o = addr_q[s];
            hit_dmi_o  = dmi_q[s];
         end
      end
   end

   always_comb begin
      free_ok_o  = 1'b0;
      free_idx_o = '0;
      for (int s = 0; s < SLOTS; s++) begin
         if (!free_ok_o && avail[s]) begin
            free_ok_o  = 1'b1;
            free_idx_o = IDX_W'(s);
         end
      end
   end

endmodule

// File: rtl/cmon_rule_eval.sv
module cmon_rule_eval
   import cmon_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 2
) (
   input  logic              ev_valid_i,
   input  phase_e            ev_phase_i,
   input  logic [ADDR_W-1:0] ev_addr_i,
   input  logic              ev_dmi_i,
   input  logic              ev_done_i,
   input  logic              two_phase_i,
   input  logic              busy_i,
   input  logic              hit_i,
   input  logic [IDX_W-1:0]  hit_idx_i,
   input  slot_st_e          hit_st_i,
   input  logic [ADDR_W-1:0] hit_addr_i,
   input  logic              hit_dmi_i,
   input  logic              free_ok_i,
   input  logic [IDX_W-1:0]  free_idx_i,
   output logic [NERR-1:0]   err_set_o,
   output logic              wr_en_o,
   output logic [IDX_W-1:0]  wr_idx_o,
   output slot_st_e          wr_st_o,
   output logic              wr_load_o,
   output logic              wr_dmi_o,
   output logic              start_o
);

   phase_e exp_ph;
   phase_e prev_ph;
   logic   tgt_ph;

   assign tgt_ph = (ev_phase_i == PH_EREQ) || (ev_phase_i == PH_BRSP);

   always_comb begin
      unique case (hit_st_i)
         ST_REQ: begin
            exp_ph  = two_phase_i ? PH_BRSP : PH_EREQ;
            prev_ph = PH_BREQ;
         end
         ST_REQ_END: begin
            exp_ph  = PH_BRSP;
            prev_ph = PH_EREQ;
         end
         ST_RESP: begin
            exp_ph  = PH_ERSP;
            prev_ph = PH_BRSP;
         end
         default: begin
            exp_ph  = PH_BREQ;
            prev_ph = PH_BREQ;
         end
      endcase
   end

   always_comb begin
      err_set_o = '0;
      wr_en_o   = 1'b0;
      wr_idx_o  = hit_idx_i;
      wr_st_o   = ST_FREE;
      wr_load_o = 1'b0;
      wr_dmi_o  = hit_dmi_i;
      start_o   = 1'b0;
      if (ev_valid_i) begin
         if (ev_phase_i == PH_BREQ) begin
            if (busy_i)   err_set_o[E_MULTI]    = 1'b1;
            if (ev_dmi_i) err_set_o[E_DMI_INIT] = 1'b1;
            if (hit_i && hit_st_i != ST_DONE) begin
               if (hit_st_i == ST_REQ) err_set_o[E_DUP]   = 1'b1;
               else                    err_set_o[E_ORDER] = 1'b1;
            end else if (!busy_i) begin
               if (hit_i) begin
                  wr_en_o  = 1'b1;
                  wr_idx_o = hit_idx_i;
               end else if (free_ok_i) begin
                  wr_en_o  = 1'b1;
                  wr_idx_o = free_idx_i;
               end else begin
                  err_set_o[E_OVERFLOW] = 1'b1;
               end
               wr_st_o   = ST_REQ;
               wr_load_o = wr_en_o;
               wr_dmi_o  = ev_dmi_i;
               start_o   = wr_en_o;
            end
         end else if (!hit_i) begin
            err_set_o[E_ORPHAN] = 1'b1;
         end else if (hit_st_i == ST_DONE) begin
            err_set_o[E_LATE] = 1'b1;
         end else if (two_phase_i &&
                      (ev_phase_i == PH_EREQ || ev_phase_i == PH_ERSP)) begin
            err_set_o[E_ORDER] = 1'b1;
         end else begin
            if (tgt_ph && (ev_addr_i != hit_addr_i)) err_set_o[E_ADDR]    = 1'b1;
            if (!tgt_ph && (ev_dmi_i != hit_dmi_i))  err_set_o[E_DMI_OWN] = 1'b1;
            if (ev_phase_i == exp_ph) begin
               wr_en_o  = 1'b1;
               wr_idx_o = hit_idx_i;
               if (tgt_ph) wr_dmi_o = ev_dmi_i;
               unique case (ev_phase_i)
                  PH_EREQ: wr_st_o = ST_REQ_END;
                  PH_BRSP: wr_st_o = two_phase_i ? ST_FREE : ST_RESP;
                  default: wr_st_o = ST_FREE;
               endcase
               if (tgt_ph && ev_done_i && (wr_st_o != ST_FREE)) wr_st_o = ST_DONE;
            end else if (ev_phase_i == prev_ph) begin
               err_set_o[E_DUP] = 1'b1;
            end else begin
               err_set_o[E_ORDER] = 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/cmon_req_timer.sv
module cmon_req_timer #(
   parameter int TMR_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             busy_i,
   input  logic [TMR_W-1:0] lim_i,
   output logic             expire_o
);

   logic [TMR_W-1:0] t_q;
   logic             fired_q;

   assign expire_o = busy_i && !fired_q && (lim_i != '0) && (t_q == lim_i);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         t_q     <= '0;
         fired_q <= 1'b0;
      end else if (start_i) begin
         t_q     <= '0;
         fired_q <= 1'b0;
      end else if (busy_i) begin
         if (expire_o)  fired_q <= 1'b1;
         if (t_q != '1) t_q     <= t_q + 1'b1;
      end
   end

endmodule

// File: rtl/cmon_err_bank.sv
module cmon_err_bank #(
   parameter int NCODE = 10,
   parameter int CNT_W = 8
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   clr_i,
   input  logic [NCODE-1:0]       set_i,
   output logic [NCODE-1:0]       flag_o,
   output logic [NCODE*CNT_W-1:0] cnt_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   for (genvar k = 0; k < NCODE; k++) begin : g_code
      logic             f_q;
      logic [CNT_W-1:0] c_q;

      always_ff @(posedge clk_i) begin
         if (!rst_ni || clr_i) begin
            f_q <= 1'b0;
            c_q <= '0;
         end else if (set_i[k]) begin
            f_q <= 1'b1;
            if (c_q != CNT_MAX) c_q <= c_q + 1'b1;
         end
      end

      assign flag_o[k]              = f_q;
      assign cnt_o[k*CNT_W +: CNT_W] = c_q;
   end

endmodule

// File: rtl/cmon_link_checker.sv
module cmon_link_checker
   import cmon_pkg::*;
#(
   parameter int ID_W   = 4,
   parameter int ADDR_W = 32,
   parameter int SLOTS  = 4,
   parameter int TMR_W  = 16,
   parameter int CNT_W  = 8
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  clr_i,
   input  logic                  two_phase_i,
   input  logic [TMR_W-1:0]      tmo_lim_i,
   input  logic                  ev_valid_i,
   input  logic [1:0]            ev_phase_i,
   input  logic [ID_W-1:0]       ev_id_i,
   input  logic [ADDR_W-1:0]     ev_addr_i,
   input  logic                  ev_dmi_i,
   input  logic                  ev_done_i,
   output logic [NERR-1:0]       err_o,
   output logic [NERR*CNT_W-1:0] err_cnt_o
);

   localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

   if (SLOTS < 1 || SLOTS > (1 << ID_W)) begin : g_bad_slots
      $error("SLOTS must lie between 1 and the number of distinct tags");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end
   if (TMR_W < 2) begin : g_bad_tmr
      $error("TMR_W must be at least 2");
   end

   phase_e            ev_ph;
   logic              hit;
   logic [IDX_W-1:0]  hit_idx;
   slot_st_e          hit_st;
   logic [ADDR_W-1:0] hit_addr;
   logic              hit_dmi;
   logic              free_ok;
   logic [IDX_W-1:0]  free_idx;
   logic              req_busy;
   logic [NERR-1:0]   rule_set;
   logic [NERR-1:0]   all_set;
   logic              wr_en;
   logic [IDX_W-1:0]  wr_idx;
   slot_st_e          wr_st;
   logic              wr_load;
   logic              wr_dmi;
   logic              tmr_start;
   logic              tmr_expire;

   assign ev_ph = phase_e'(ev_phase_i);

   cmon_slot_table #(
      .ID_W   (ID_W),
      .ADDR_W (ADDR_W),
      .SLOTS  (SLOTS),
      .IDX_W  (IDX_W)
   ) i_table (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .lk_id_i    (ev_id_i),
      .wr_en_i    (wr_en),
      .wr_idx_i   (wr_idx),
      .wr_load_i  (wr_load),
      .wr_st_i    (wr_st),
      .wr_addr_i  (ev_addr_i),
      .wr_dmi_i   (wr_dmi),
      .hit_o      (hit),
      .hit_idx_o  (hit_idx),
      .hit_st_o   (hit_st),
      .hit_addr_o (hit_addr),
      .hit_dmi_o  (hit_dmi),
      .free_ok_o  (free_ok),
      .free_idx_o (free_idx),
      .req_busy_o (req_busy)
   );

   cmon_rule_eval #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W)
   ) i_rules (
      .ev_valid_i  (ev_valid_i),
      .ev_phase_i  (ev_ph),
      .ev_addr_i   (ev_addr_i),
      .ev_dmi_i    (ev_dmi_i),
      .ev_done_i   (ev_done_i),
      .two_phase_i (two_phase_i),
      .busy_i      (req_busy),
      .hit_i       (hit),
      .hit_idx_i   (hit_idx),
      .hit_st_i    (hit_st),
      .hit_addr_i  (hit_addr),
      .hit_dmi_i   (hit_dmi),
      .free_ok_i   (free_ok),
      .free_idx_i  (free_idx),
      .err_set_o   (rule_set),
      .wr_en_o     (wr_en),
      .wr_idx_o    (wr_idx),
      .wr_st_o     (wr_st),
      .wr_load_o   (wr_load),
      .wr_dmi_o    (wr_dmi),
      .start_o     (tmr_start)
   );

   cmon_req_timer #(
      .TMR_W (TMR_W)
   ) i_timer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (tmr_start),
      .busy_i   (req_busy),
      .lim_i    (tmo_lim_i),
      .expire_o (tmr_expire)
   );

   always_comb begin
      all_set            = rule_set;
      all_set[E_TIMEOUT] = tmr_expire;
   end

   cmon_err_bank #(
      .NCODE (NERR),
      .CNT_W (CNT_W)
   ) i_errs (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_i),
      .set_i  (all_set),
      .flag_o (err_o),
      .cnt_o  (err_cnt_o)
   );

endmodule

// File: rtl/cmon_link_checker_sva.sv
module cmon_link_checker_sva
   import cmon_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input logic                  clk_i,
   input logic                  rst_ni,
   input logic                  clr_i,
   input logic                  two_phase_i,
   input logic                  ev_valid_i,
   input logic [1:0]            ev_phase_i,
   input logic                  ev_dmi_i,
   input logic                  busy,
   input logic [NERR-1:0]       err_o,
   input logic [NERR*CNT_W-1:0] err_cnt_o
);

   localparam logic [NERR-1:0] ORDER_LIKE =
      NERR'((1 << E_ORDER) | (1 << E_ORPHAN) | (1 << E_LATE));

   AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_i |=> ((err_o & $past(err_o)) == $past(err_o))); // R12

   AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (err_o == '0)); // R12

   AST_DMI_AT_BREQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_valid_i && ev_phase_i == 2'd0 && ev_dmi_i && !clr_i) |=> err_o[E_DMI_INIT]); // R5

   AST_ONE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_valid_i && ev_phase_i == 2'd0 && busy && !clr_i) |=> err_o[E_MULTI]); // R3

   AST_TWO_PHASE_EREQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (two_phase_i && ev_valid_i && ev_phase_i == 2'd1 && !clr_i)
         |=> ((err_o & ORDER_LIKE) != '0)); // R11

   for (genvar k = 0; k < NERR; k++) begin : g_code
      AST_FLAG_MATCHES_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
         err_o[k] == (err_cnt_o[k*CNT_W +: CNT_W] != '0)); // R13

      AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !clr_i |=> (err_cnt_o[k*CNT_W +: CNT_W] >= $past(err_cnt_o[k*CNT_W +: CNT_W]))); // R13
   end

endmodule

bind cmon_link_checker cmon_link_checker_sva #(.CNT_W(CNT_W)) i_sva (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .clr_i       (clr_i),
   .two_phase_i (two_phase_i),
   .ev_valid_i  (ev_valid_i),
   .ev_phase_i  (ev_phase_i),
   .ev_dmi_i    (ev_dmi_i),
   .busy        (req_busy),
   .err_o       (err_o),
   .err_cnt_o   (err_cnt_o)
);

// File: tb/test_cmon_link_checker.sv
`timescale 1ns/1ps
module test_cmon_link_checker;

   localparam int ID_W   = 4;
   localparam int ADDR_W = 32;
   localparam int SLOTS  = 4;
   localparam int TMR_W  = 16;
   localparam int CNT_W  = 8;
   localparam int NE     = 10;

   logic                clk = 1'b0;
   logic                rst_n;
   logic                clr;
   logic                two;
   logic [TMR_W-1:0]    lim;
   logic                valid;
   logic [1:0]          phase;
   logic [ID_W-1:0]     id;
   logic [ADDR_W-1:0]   addr;
   logic                dmi;
   logic                done;
   logic [NE-1:0]       err;
   logic [NE*CNT_W-1:0] cnt;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   cmon_link_checker #(
      .ID_W(ID_W), .ADDR_W(ADDR_W), .SLOTS(SLOTS), .TMR_W(TMR_W), .CNT_W(CNT_W)
   ) i_cmon_link_checker (
      .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .two_phase_i(two),
      .tmo_lim_i(lim), .ev_valid_i(valid), .ev_phase_i(phase), .ev_id_i(id),
      .ev_addr_i(addr), .ev_dmi_i(dmi), .ev_done_i(done),
      .err_o(err), .err_cnt_o(cnt)
   );

   // row layout: [35:32] req, [31] clr, [30] two-phase, [29] valid,
   // [28:27] phase, [26:23] tag, [22:15] addr, [14] dmi, [13] done, [9:0] expected flags
   function automatic logic [35:0] ev4(input int ph, input int t, input int ad,
                                       input logic d, input logic dn,
                                       input int ex, input int rq);
      logic [35:0] r;
      r = '0;
      r[35:32] = rq[3:0]; r[29] = 1'b1; r[28:27] = ph[1:0]; r[26:23] = t[3:0];
      r[22:15] = ad[7:0]; r[14] = d; r[13] = dn; r[9:0] = ex[9:0];
      return r;
   endfunction

   function automatic logic [35:0] ev2(input int ph, input int t, input int ad,
                                       input int ex, input int rq);
      logic [35:0] r;
      r = ev4(ph, t, ad, 1'b0, 1'b0, ex, rq);
      r[30] = 1'b1;
      return r;
   endfunction

   function automatic logic [35:0] clrow(input logic t2, input int rq);
      logic [35:0] r;
      r = '0;
      r[35:32] = rq[3:0]; r[31] = 1'b1; r[30] = t2;
      return r;
   endfunction

   localparam int NV = 58;
   localparam logic [35:0] VEC [NV] = '{
      clrow(1'b0, 12),
      ev4(0, 1, 'h10, 0, 0, 'h000, 1),   // R1 legal four-phase flow
      ev4(1, 1, 'h10, 0, 0, 'h000, 1),
      ev4(2, 1, 'h10, 0, 0, 'h000, 1),
      ev4(3, 1, 'h10, 0, 0, 'h000, 1),
      ev4(1, 1, 'h10, 0, 0, 'h080, 8),   // R8 tag released
      clrow(1'b0, 12),
      ev4(0, 3, 'h30, 0, 0, 'h000, 3),   // R3 second request while busy
      ev4(0, 4, 'h40, 0, 0, 'h004, 3),
      ev4(1, 3, 'h30, 0, 0, 'h004, 3),
      ev4(1, 4, 'h40, 0, 0, 'h084, 3),   // R3 rejected request untracked
      clrow(1'b0, 12),
      ev4(2, 3, 'h30, 0, 0, 'h000, 1),
      ev4(3, 3, 'h30, 0, 0, 'h000, 1),
      ev4(0, 5, 'h50, 0, 0, 'h000, 2),   // R2 duplicate end-request
      ev4(1, 5, 'h50, 0, 0, 'h000, 2),
      ev4(1, 5, 'h50, 0, 0, 'h002, 2),
      clrow(1'b0, 12),
      ev4(3, 5, 'h50, 0, 0, 'h001, 1),   // R1 skipped phase
      ev4(2, 5, 'h50, 0, 0, 'h001, 1),
      ev4(3, 5, 'h50, 0, 0, 'h001, 1),
      clrow(1'b0, 12),
      ev4(0, 6, 'h60, 1, 0, 'h010, 5),   // R5 permission high at request
      ev4(1, 6, 'h60, 1, 0, 'h010, 6),
      clrow(1'b0, 12),
      ev4(2, 6, 'h60, 1, 0, 'h000, 6),
      ev4(3, 6, 'h60, 0, 0, 'h020, 6),   // R6 initiator changed permission
      clrow(1'b0, 12),
      ev4(0, 7, 'h70, 0, 0, 'h000, 6),   // R6 target raises permission
      ev4(1, 7, 'h70, 1, 0, 'h000, 6),
      ev4(2, 7, 'h70, 1, 0, 'h000, 6),
      ev4(3, 7, 'h70, 1, 0, 'h000, 6),
      ev4(0, 8, 'h20, 0, 0, 'h000, 7),   // R7 target alters address
      ev4(1, 8, 'h24, 0, 0, 'h040, 7),
      ev4(2, 8, 'h20, 0, 0, 'h040, 7),
      ev4(3, 8, 'h99, 0, 0, 'h040, 7),
      clrow(1'b0, 12),
      ev4(0, 9, 'h90, 0, 0, 'h000, 4),   // R4 early end at end-request
      ev4(1, 9, 'h90, 0, 1, 'h000, 4),
      ev4(2, 9, 'h90, 0, 0, 'h008, 4),
      clrow(1'b0, 12),
      ev4(0, 9, 'h90, 0, 0, 'h000, 4),   // R4 tag reused after early end
      ev4(1, 9, 'h90, 0, 0, 'h000, 4),
      ev4(2, 9, 'h90, 0, 1, 'h000, 4),
      ev4(3, 9, 'h90, 0, 0, 'h008, 4),
      clrow(1'b1, 12),
      ev2(0, 10, 'hA0, 'h000, 11),       // R11 call and return
      ev2(2, 10, 'hA0, 'h000, 11),
      ev2(2, 10, 'hA0, 'h080, 11),
      clrow(1'b1, 12),
      ev2(0, 11, 'hB0, 'h000, 11),
      ev2(1, 11, 'hB0, 'h001, 11),       // R11 end-request illegal
      ev2(2, 11, 'hB0, 'h001, 11),
      clrow(1'b1, 12),
      ev2(0, 12, 'hC0, 'h000, 11),
      ev2(0, 13, 'hD0, 'h004, 11),       // R11 with R3 in two-phase
      ev2(2, 12, 'hC0, 'h004, 11),
      clrow(1'b0, 12)
   };

   task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic pulse(input int ph, input int t, input int ad, input logic d, input logic dn);
      valid = 1'b1; phase = ph[1:0]; id = t[ID_W-1:0]; addr = ADDR_W'(ad);
      dmi = d; done = dn;
      @(negedge clk);
      valid = 1'b0; dmi = 1'b0; done = 1'b0;
   endtask

   task automatic do_clr();
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; clr = 1'b0; two = 1'b0; lim = '0; valid = 1'b0;
      phase = '0; id = '0; addr = '0; dmi = 1'b0; done = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R14 flags after reset", 64'(err), 64'(0));
      check("R14 counters after reset", 64'(cnt), 64'(0));

      for (int i = 0; i < NV; i++) begin
         clr   = VEC[i][31];
         two   = VEC[i][30];
         valid = VEC[i][29];
         phase = VEC[i][28:27];
         id    = VEC[i][26:23];
         addr  = ADDR_W'(VEC[i][22:15]);
         dmi   = VEC[i][14];
         done  = VEC[i][13];
         @(negedge clk);
         valid = 1'b0; clr = 1'b0; dmi = 1'b0; done = 1'b0;
         check($sformatf("R%0d table row %0d", VEC[i][35:32], i), 64'(err), 64'(VEC[i][9:0]));
      end

      // R13 counting and saturation on the orphan code (field 7)
      two = 1'b0;
      do_clr();
      for (int n = 0; n < 3; n++) pulse(1, 15, 0, 1'b0, 1'b0);
      check("R13 orphan count of three", 64'(cnt[7*CNT_W +: CNT_W]), 64'(3));
      check("R8 orphan flag", 64'(err), 64'('h080));
      for (int n = 0; n < 300; n++) pulse(1, 15, 0, 1'b0, 1'b0);
      check("R13 counter saturates", 64'(cnt[7*CNT_W +: CNT_W]), 64'(255));
      clr = 1'b1;
      pulse(1, 15, 0, 1'b0, 1'b0);
      clr = 1'b0;
      check("R12 clear wins over same-cycle event", 64'(err), 64'(0));
      check("R13 clear zeroes counters", 64'(cnt), 64'(0));

      // R10 table full
      for (int t = 1; t <= 4; t++) begin
         pulse(0, t, t * 16, 1'b0, 1'b0);
         pulse(1, t, t * 16, 1'b0, 1'b0);
      end
      check("R10 four live transactions accepted", 64'(err), 64'(0));
      pulse(0, 5, 'h55, 1'b0, 1'b0);
      check("R10 overflow flagged", 64'(err), 64'('h200));
      for (int t = 1; t <= 4; t++) begin
         pulse(2, t, t * 16, 1'b0, 1'b0);
         pulse(3, t, t * 16, 1'b0, 1'b0);
      end
      do_clr();
      pulse(0, 5, 'h55, 1'b0, 1'b0);
      pulse(1, 5, 'h55, 1'b0, 1'b0);
      pulse(2, 5, 'h55, 1'b0, 1'b0);
      pulse(3, 5, 'h55, 1'b0, 1'b0);
      check("R10 accepted again after release", 64'(err), 64'(0));

      // R9 end-request timeout
      lim = TMR_W'(5);
      pulse(0, 6, 'h66, 1'b0, 1'b0);
      repeat (10) @(negedge clk);
      check("R9 timeout raised", 64'(err), 64'('h100));
      pulse(1, 6, 'h66, 1'b0, 1'b0);
      pulse(2, 6, 'h66, 1'b0, 1'b0);
      pulse(3, 6, 'h66, 1'b0, 1'b0);
      do_clr();
      pulse(0, 7, 'h77, 1'b0, 1'b0);
      repeat (2) @(negedge clk);
      pulse(1, 7, 'h77, 1'b0, 1'b0);
      repeat (10) @(negedge clk);
      check("R9 prompt end-request no timeout", 64'(err), 64'(0));
      pulse(2, 7, 'h77, 1'b0, 1'b0);
      pulse(3, 7, 'h77, 1'b0, 1'b0);
      lim = '0;
      pulse(0, 8, 'h88, 1'b0, 1'b0);
      repeat (20) @(negedge clk);
      check("R9 zero limit disables timeout", 64'(err), 64'(0));
      pulse(1, 8, 'h88, 1'b0, 1'b0);
      pulse(2, 8, 'h88, 1'b0, 1'b0);
      pulse(3, 8, 'h88, 1'b0, 1'b0);
      check("R1 clean flow leaves flags clear", 64'(err), 64'(0));

      finish_run();
   end

endmodule